// File: doc/BRIEF.md
# Configurable Cascaded Sinc Decimator

This block reduces the word rate of a multi-bit sample stream that a coarse decimator has already produced. It holds five sinc decimation stages in a fixed chain. Each stage is a short FIR whose tap weights are binomial coefficients. A stage that is switched on registers one filtered word per R accepted input words, where R is 2 or 3. A stage that is switched off passes its input through in the same cycle.

Two configuration fields choose which stages are on: a 3-bit path select and a 3-bit rate code. The combinations give overall decimation factors of 2, 4, 8, 12 and 16. Every stage keeps full precision: the data word is wide enough for the largest gain any allowed combination can reach, so nothing is truncated. A change of either configuration field clears all phase counters and delay lines, so the new rate starts from a known state.

Top module: `sinc_cascade`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `out_vld` is 0.
- R2: Stages are numbered 1 to 5 along the chain. Stage 1 is 4th order with decimation 2. Stage 2 is 4th order with decimation 3. Stage 3 is 4th order with decimation 2. Stages 4 and 5 are 5th order with decimation 2. A 4th-order stage uses taps 1,4,6,4,1 and a 5th-order stage uses taps 1,5,10,10,5,1. A disabled stage passes its input to the next stage unchanged.
- R3: For path select 2 through 7, the rate code selects these stages: 7 selects {5}; 6 selects {4,5}; 5 and 2 select {3,4,5}; 4, 1 and 0 select {1,3,4,5}; 3 selects {2,4,5}.
- R4: For path select 1, the rate code selects these stages: 7 selects {4,5}; 6 and 4 select {3,4,5}; 3 selects {2,4,5}; 5, 2, 1 and 0 select {1,3,4,5}.
- R5: For path select 0, every rate code selects {1,3,4,5}, which is an overall decimation of 16.
- R6: After a clear, `out_vld` pulses for exactly one cycle per D accepted input words, where D is the product of the enabled stages' ratios. Two pulses are never adjacent.
- R7: For a constant input c, the settled output equals c multiplied by the product of the enabled stages' DC gains (16 for 4th order, 32 for 5th order). This holds without overflow at full-scale input of either sign.
- R8: A stage emits on every R-th input it accepts after a clear. The output is the tap-weighted sum of that input and the ORDER inputs before it, with the newest input taking the first tap. Example: with only stage 5 enabled, an impulse of height A followed by zeros gives the outputs 5A, 10A, A, 0.
- R9: In a cycle where {`path_sel`,`rate_code`} differs from its registered value, every stage clears its delay line and phase counter and drops any input word. The rate then restarts as in R6, with empty history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_sel | input | 3 | Filter-path select |
| rate_code | input | 3 | Rate code; together with path_sel it chooses the stages |
| in_vld | input | 1 | Input word strobe |
| in_dat | input | IN_W | Signed input sample |
| out_vld | output | 1 | Single-cycle output strobe |
| out_dat | output | OUT_W | Signed decimated sample, IN_W+18 bits by default |

## Verification
Any fault in a stage's phase counter shows up in the pulse count and in how the strobes are spaced. With ratio 16 it is visible within 16 input words: strobes come early, come late, or sit next to each other. A corrupted delay line or wrong tap weight changes the settled DC value and the impulse sequence at the first output that uses the bad entry. Stale state after a configuration change is visible on the very first output, which then carries a nonzero residue or arrives before the Dth input.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

    localparam int NUM_STG = 5;

    // Filter order of stage index i (0-based): stages 1..3 are 4th order, 4..5 are 5th order
    function automatic int stg_order(input int i);
        return (i < 3) ? 4 : 5;
    endfunction

    // Decimation ratio of stage index i: only the second stage divides by three
    function automatic int stg_ratio(input int i);
        return (i == 1) ? 3 : 2;
    endfunction

    // Binomial coefficient n choose k
    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        for (int j = 1; j <= k; j++) begin
            r = (r * (n - j + 1)) / j;
        end
        return r;
    endfunction

    // DC gain of an order-N binomial kernel is 2**N, so growth in bits equals the order.
    // Stages 1 and 2 are never enabled together; the deepest path is {1,3,4,5}.
    localparam int MAX_GROW = stg_order(0) + stg_order(2) + stg_order(3) + stg_order(4);

    typedef logic [NUM_STG-1:0] stg_mask_t;

endpackage

// File: rtl/sinc_rate_decode.sv
module sinc_rate_decode
    import sinc_pkg::*;
(
    input  logic [2:0] path_sel,
    input  logic [2:0] rate_code,
    output stg_mask_t  stg_en
);

    // Bit i enables stage i+1
    localparam stg_mask_t M_5     = 5'b10000;
    localparam stg_mask_t M_45    = 5'b11000;
    localparam stg_mask_t M_345   = 5'b11100;
    localparam stg_mask_t M_1345  = 5'b11101;
    localparam stg_mask_t M_245   = 5'b11010;

    always_comb begin
        stg_en = M_1345;
        if (path_sel == 3'd0) begin
            stg_en = M_1345;
        end else if (path_sel == 3'd1) begin
            unique case (rate_code)
                3'd7:         stg_en = M_45;
                3'd6, 3'd4:   stg_en = M_345;
                3'd3:         stg_en = M_245;
                default:      stg_en = M_1345;
            endcase
        end else begin
            unique case (rate_code)
                3'd7:         stg_en = M_5;
                3'd6:         stg_en = M_45;
                3'd5, 3'd2:   stg_en = M_345;
                3'd3:         stg_en = M_245;
                default:      stg_en = M_1345;
            endcase
        end
    end

endmodule

// File: rtl/sinc_stage.sv
module sinc_stage #(
    parameter int DW    = 34,
    parameter int ORDER = 4,
    parameter int RATIO = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_dat,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_dat
);

    localparam int PW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(RATIO - 1);

    typedef struct packed {
        logic [PW-1:0]              phase;
        logic [ORDER-1:0][DW-1:0]   hist;
        logic                       vld;
        logic [DW-1:0]              dat;
    } stage_t;

    stage_t st_d, st_q;
    logic signed [DW-1:0] acc;
    logic signed [DW-1:0] cw;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;

        cw  = DW'(sinc_pkg::binom(ORDER, 0));
        acc = in_dat * cw;
        for (int k = 1; k <= ORDER; k++) begin
            cw  = DW'(sinc_pkg::binom(ORDER, k));
            acc = acc + $signed(st_q.hist[k-1]) * cw;
        end

        if (clr) begin
            st_d = '0;
        end else if (en && in_vld) begin
            st_d.hist[0] = in_dat;
            for (int k = 1; k < ORDER; k++) begin
                st_d.hist[k] = st_q.hist[k-1];
            end
            if (st_q.phase == LAST_PH) begin
                st_d.phase = '0;
                st_d.vld   = 1'b1;
                st_d.dat   = acc;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = en ? st_q.vld : in_vld;
    assign out_dat = en ? $signed(st_q.dat) : in_dat;

    // R8: phase counter stays inside its modulus
    a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= LAST_PH);

    // R6: a registered output needs an accepted input one cycle earlier
    a_r6_vld_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(in_vld && en && !clr));

    // R9: a clear leaves the stage silent and empty
    a_r9_clr_silences: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!st_q.vld && st_q.phase == '0 && st_q.hist == '0));

endmodule

// File: rtl/sinc_cascade.sv
module sinc_cascade #(
    parameter int IN_W  = 16,
    parameter int OUT_W = IN_W + sinc_pkg::MAX_GROW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              path_sel,
    input  logic [2:0]              rate_code,
    input  logic                    in_vld,
    input  logic signed [IN_W-1:0]  in_dat,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_dat
);
    import sinc_pkg::*;

    localparam int EXT_W = OUT_W - IN_W;

    typedef struct packed {
        logic [2:0] path;
        logic [2:0] code;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    logic      clr;
    stg_mask_t stg_en;

    always_comb begin
        cfg_d.path = path_sel;
        cfg_d.code = rate_code;
        clr        = (cfg_d != cfg_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    sinc_rate_decode u_dec (
        .path_sel  (cfg_q.path),
        .rate_code (cfg_q.code),
        .stg_en    (stg_en)
    );

    logic [NUM_STG:0]            vld_c;
    logic [NUM_STG:0][OUT_W-1:0] dat_c;

    assign vld_c[0] = in_vld;
    assign dat_c[0] = {{EXT_W{in_dat[IN_W-1]}}, in_dat};

    for (genvar g = 0; g < NUM_STG; g++) begin : g_stg
        logic signed [OUT_W-1:0] s_out;
        sinc_stage #(
            .DW    (OUT_W),
            .ORDER (stg_order(g)),
            .RATIO (stg_ratio(g))
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .en      (stg_en[g]),
            .in_vld  (vld_c[g]),
            .in_dat  ($signed(dat_c[g])),
            .out_vld (vld_c[g+1]),
            .out_dat (s_out)
        );
        assign dat_c[g+1] = s_out;
    end

    assign out_vld = vld_c[NUM_STG];
    assign out_dat = $signed(dat_c[NUM_STG]);

    // R6: output strobe lasts a single cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);

    // R3: the last stage is part of every decoded set
    a_r3_last_stage_on: assert property (@(posedge clk) disable iff (!rst_n)
        stg_en[NUM_STG-1] && !(stg_en[0] && stg_en[1]));

endmodule

// File: tb/sinc_cascade_tb.sv
module sinc_cascade_tb;

    localparam int IN_W  = 16;
    localparam int OUT_W = 34;

    logic                    clk;
    logic                    rst_n;
    logic [2:0]              path_sel;
    logic [2:0]              rate_code;
    logic                    in_vld;
    logic signed [IN_W-1:0]  in_dat;
    logic                    out_vld;
    logic signed [OUT_W-1:0] out_dat;

    int checks;
    int errors;

    sinc_cascade #(.IN_W(IN_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .path_sel  (path_sel),
        .rate_code (rate_code),
        .in_vld    (in_vld),
        .in_dat    (in_dat),
        .out_vld   (out_vld),
        .out_dat   (out_dat)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Output monitor: running count, log of values, adjacent-strobe detector
    int     mon_cnt;
    int     dbl_cnt;
    logic   prev_vld;
    longint rec [0:4095];

    initial begin
        mon_cnt  = 0;
        dbl_cnt  = 0;
        prev_vld = 1'b0;
    end

    always @(negedge clk) begin
        if (out_vld) begin
            if (mon_cnt < 4096) rec[mon_cnt] = longint'(out_dat);
            mon_cnt = mon_cnt + 1;
            if (prev_vld) dbl_cnt = dbl_cnt + 1;
        end
        prev_vld = out_vld;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] p, input logic [2:0] c,
                           input bit stray, input logic signed [IN_W-1:0] v);
        @(negedge clk);
        path_sel  = p;
        rate_code = c;
        in_vld    = stray;
        in_dat    = v;
        @(negedge clk);
        in_vld    = 1'b0;
        in_dat    = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic feed(input int n, input logic signed [IN_W-1:0] v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b1;
            in_dat = v;
        end
        @(negedge clk);
        in_vld = 1'b0;
        in_dat = '0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    // R1: no output strobe during or just after reset
    task automatic t_reset();
        int base;
        base = mon_cnt;
        repeat (5) @(negedge clk);
        chk(out_vld == 1'b0 && mon_cnt == base, "R1 reset out_vld", longint'(mon_cnt - base), 0);
    endtask

    // R3/R4/R5/R6/R7: pulse count over 240 constant words and settled DC value
    task automatic t_rate(input string req, input logic [2:0] p, input logic [2:0] c,
                          input int ratio, input longint gain,
                          input logic signed [IN_W-1:0] v);
        int base;
        longint exp_v;
        set_cfg(p, c, 1'b0, '0);
        base = mon_cnt;
        feed(240, v);
        settle();
        chk(mon_cnt - base == 240 / ratio, {req, " R6 pulse count"},
            longint'(mon_cnt - base), longint'(240 / ratio));
        exp_v = longint'(v) * gain;
        chk(mon_cnt > base && rec[mon_cnt-1] == exp_v, {req, " R7 settled dc"},
            (mon_cnt > base) ? rec[mon_cnt-1] : -1, exp_v);
    endtask

    // R8: impulse through stage 5 alone
    task automatic t_impulse();
        int base;
        longint exp_seq [4];
        exp_seq = '{5000, 10000, 1000, 0};
        set_cfg(3'd2, 3'd7, 1'b0, '0);
        base = mon_cnt;
        feed(1, 16'sd1000);
        feed(7, 16'sd0);
        settle();
        chk(mon_cnt - base == 4, "R8 impulse count", longint'(mon_cnt - base), 4);
        for (int i = 0; i < 4; i++) begin
            chk(rec[base+i] == exp_seq[i], "R8 impulse tap", rec[base+i], exp_seq[i]);
        end
    endtask

    // R9: config change clears history and phase, and drops the stray word
    task automatic t_clear();
        int base;
        set_cfg(3'd2, 3'd6, 1'b0, '0);
        set_cfg(3'd2, 3'd7, 1'b0, '0);
        feed(7, 16'sd1000);
        settle();
        set_cfg(3'd1, 3'd7, 1'b1, 16'sd5000);
        base = mon_cnt;
        feed(3, 16'sd0);
        settle();
        chk(mon_cnt - base == 0, "R9 no early output", longint'(mon_cnt - base), 0);
        feed(1, 16'sd0);
        settle();
        chk(mon_cnt - base == 1, "R9 first output on 4th word", longint'(mon_cnt - base), 1);
        chk(mon_cnt > base && rec[mon_cnt-1] == 0, "R9 history cleared",
            (mon_cnt > base) ? rec[mon_cnt-1] : -1, 0);
    endtask

    initial begin
        checks    = 0;
        errors    = 0;
        rst_n     = 1'b0;
        path_sel  = 3'd0;
        rate_code = 3'd0;
        in_vld    = 1'b0;
        in_dat    = '0;
        repeat (2) @(negedge clk);
        chk(out_vld == 1'b0, "R1 in reset", longint'(out_vld), 0);
        rst_n = 1'b1;
        t_reset();

        // R3 / R2: paths 2..7
        t_rate("R3 p2c7 {5}",      3'd2, 3'd7, 2,  32,     16'sd100);
        t_rate("R3 p3c6 {4,5}",    3'd3, 3'd6, 4,  1024,   16'sd100);
        t_rate("R3 p4c5 {3,4,5}",  3'd4, 3'd5, 8,  16384,  -16'sd3);
        t_rate("R3 p5c4 {1,3,4,5}",3'd5, 3'd4, 16, 262144, 16'sd77);
        t_rate("R3 p2c3 {2,4,5}",  3'd2, 3'd3, 12, 16384,  16'sd100);
        t_rate("R3 p6c2 {3,4,5}",  3'd6, 3'd2, 8,  16384,  16'sd9);
        t_rate("R3 p7c1 {1,3,4,5}",3'd7, 3'd1, 16, 262144, -16'sd5);
        // R4: path 1
        t_rate("R4 p1c7 {4,5}",    3'd1, 3'd7, 4,  1024,   16'sd100);
        t_rate("R4 p1c6 {3,4,5}",  3'd1, 3'd6, 8,  16384,  16'sd100);
        t_rate("R4 p1c5 {1,3,4,5}",3'd1, 3'd5, 16, 262144, 16'sd100);
        t_rate("R4 p1c3 {2,4,5}",  3'd1, 3'd3, 12, 16384,  -16'sd100);
        t_rate("R4 p1c2 {1,3,4,5}",3'd1, 3'd2, 16, 262144, 16'sd11);
        // R5: path 0, full scale both signs (R7 boundary)
        t_rate("R5 p0c7 neg full", 3'd0, 3'd7, 16, 262144, -16'sd32768);
        t_rate("R5 p0c0 pos full", 3'd0, 3'd0, 16, 262144, 16'sd32767);

        t_impulse();
        t_clear();

        chk(dbl_cnt == 0, "R6 adjacent strobes", longint'(dbl_cnt), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

endmodule